// File: doc/BRIEF.md
# Per-Cycle Cache Port Limiter

This block sits beside a load-store unit and keeps a budget of data-cache ports for each issue cycle. It holds separate budgets for load ports and store ports, each sized by a parameter. Request clients read a combinational "port free" flag for each kind. When they issue, they present the number of ports they are taking this cycle as a count on a claim input. The block adds up the claims and withholds availability once a budget is spent.

A pipeline cycle is marked by a tick strobe. On a tick both budgets start again. Claims presented in the same clock as the tick are charged to the new cycle. The block also tracks whether the memory side is refusing requests. A set strobe raises a sticky blocked flag, and a retry strobe from memory clears it. A wake-up output tells the issue stage to re-issue held loads. It fires when a tick closes a cycle in which all load ports were used and the cache was not blocked. It also fires on every retry. A context takeover empties the store budget and clears the blocked flag.

Top module: `cache_port_limiter`

## Requirements
- R1: `ld_avail_o` is 1 exactly when the load count held in `ld_used_o` is below `LD_PORTS`.
- R2: `st_avail_o` is 1 exactly when the store count held in `st_used_o` is below `ST_PORTS`.
- R3: Outside tick and takeover clocks, each used count grows by its claim input on every clock edge. A count at its limit with a zero claim stays at the limit.
- R4: On a clock with `tick_i` high, both used counts become equal to that clock's claim values. Claims on the tick are charged to the new cycle.
- R5: `wake_o` is 1 in a clock with `tick_i` high, `ld_used_o` equal to `LD_PORTS` and `blocked_o` low. It is 0 in a tick clock while `blocked_o` is high, unless `retry_i` is high.
- R6: `retry_i` drives `wake_o` high in the same clock, and `blocked_o` reads 0 after the next edge.
- R7: `blk_set_i` makes `blocked_o` 1 after the edge, and it stays 1 until a retry or a takeover. When set and retry are high in the same clock, the result is 0.
- R8: `takeover_i` clears the store count (the store claim of that clock is charged fresh) and clears `blocked_o`. The load count is unaffected.
- R9: A claim larger than the remaining budget of its kind is illegal and is flagged by an assertion. The counters never exceed their limits.
- R10: After reset, both counts are 0, both available flags are 1, `blocked_o` is 0 and `wake_o` is 0 with idle inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Pipeline cycle boundary strobe |
| ld_claim_i | input | LD_CW | Load ports claimed this clock |
| st_claim_i | input | ST_CW | Store ports claimed this clock |
| blk_set_i | input | 1 | Memory side refused a send |
| retry_i | input | 1 | Memory side invites a retry |
| takeover_i | input | 1 | Context takeover |
| ld_avail_o | output | 1 | A load port is free |
| st_avail_o | output | 1 | A store port is free |
| ld_used_o | output | LD_CW | Load ports used in the current cycle |
| st_used_o | output | ST_CW | Store ports used in the current cycle |
| blocked_o | output | 1 | Sticky cache-blocked flag |
| wake_o | output | 1 | Re-issue wake-up to the issue stage |

## Verification
Several pairs of events can land in the same clock: a tick with fresh claims, a tick with a blocked cache, a set with a retry, and a takeover with a store claim. Directed steps place each pair in one clock on purpose. A long stretch of random legal stimulus then raises tick, set, retry and takeover independently, so all of these pairs recur. On every clock a behavioural model in the bench predicts the counts, flags and wake-up from the requirement rules, and the design's outputs are compared against it.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  typedef struct packed {
    logic set;
    logic retry;
    logic takeover;
  } blk_ctrl_t;
endpackage

// File: rtl/port_budget.sv
module port_budget #(
  parameter int LIMIT = 2,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [CW-1:0] claim_i,
  output logic [CW-1:0] used_o,
  output logic          avail_o
);
  localparam logic [CW:0] LIM_W = (CW+1)'(LIMIT);

  logic [CW-1:0] used_q, base;
  logic [CW:0]   sum;
  logic [CW-1:0] used_d;

  assign base   = clear_i ? '0 : used_q;
  assign sum    = {1'b0, base} + {1'b0, claim_i};
  // saturate at the limit
  assign used_d = (sum > LIM_W) ? LIM_W[CW-1:0] : sum[CW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else         used_q <= used_d;
  end

  assign used_o  = used_q;
  assign avail_o = ({1'b0, used_q} < LIM_W);

  AST_NO_OVERCLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, base} + {1'b0, claim_i}) <= LIM_W); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && claim_i == '0) |=> (used_o == '0)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && claim_i == '0) |=> $stable(used_o)); // R3
endmodule

// File: rtl/blocked_tracker.sv
module blocked_tracker
  import cpl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  blk_ctrl_t ctrl_i,
  output logic      blocked_o
);
  logic blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               blk_q <= 1'b0;
    else if (ctrl_i.retry || ctrl_i.takeover)  blk_q <= 1'b0;  // clear wins
    else if (ctrl_i.set)                       blk_q <= 1'b1;
  end

  assign blocked_o = blk_q;

  AST_RETRY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.retry |=> !blocked_o); // R6
  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.set && !ctrl_i.retry && !ctrl_i.takeover) |=> blocked_o); // R7
  AST_BLOCK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blocked_o) |-> $past(ctrl_i.set)); // R7
endmodule

// File: rtl/cache_port_limiter.sv
module cache_port_limiter
  import cpl_pkg::*;
#(
  parameter int LD_PORTS = 2,
  parameter int ST_PORTS = 1,
  localparam int LD_CW = $clog2(LD_PORTS + 1),
  localparam int ST_CW = $clog2(ST_PORTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [LD_CW-1:0] ld_claim_i,
  input  logic [ST_CW-1:0] st_claim_i,
  input  logic             blk_set_i,
  input  logic             retry_i,
  input  logic             takeover_i,
  output logic             ld_avail_o,
  output logic             st_avail_o,
  output logic [LD_CW-1:0] ld_used_o,
  output logic [ST_CW-1:0] st_used_o,
  output logic             blocked_o,
  output logic             wake_o
);
  blk_ctrl_t ctrl;

  port_budget #(.LIMIT(LD_PORTS)) u_ld (
    .clk_i, .rst_ni,
    .clear_i (tick_i),
    .claim_i (ld_claim_i),
    .used_o  (ld_used_o),
    .avail_o (ld_avail_o)
  );

  port_budget #(.LIMIT(ST_PORTS)) u_st (
    .clk_i, .rst_ni,
    .clear_i (tick_i | takeover_i),
    .claim_i (st_claim_i),
    .used_o  (st_used_o),
    .avail_o (st_avail_o)
  );

  assign ctrl = '{set: blk_set_i, retry: retry_i, takeover: takeover_i};

  blocked_tracker u_blk (
    .clk_i, .rst_ni,
    .ctrl_i    (ctrl),
    .blocked_o (blocked_o)
  );

  // loads throttled by the port budget, not by a blocked cache
  assign wake_o = (tick_i && !ld_avail_o && !blocked_o) || retry_i;

  AST_TKO_KEEPS_LD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (takeover_i && !tick_i && ld_claim_i == '0) |=> $stable(ld_used_o)); // R8
  AST_TKO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takeover_i |=> !blocked_o); // R8
endmodule

// File: tb/cache_port_limiter_test.sv
`timescale 1ns/1ps
module cache_port_limiter_test;
  localparam int LD = 2;
  localparam int ST = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, blk_set_i = 0, retry_i = 0, takeover_i = 0;
  logic [1:0] ld_claim_i = '0;
  logic [0:0] st_claim_i = '0;
  logic ld_avail_o, st_avail_o, blocked_o, wake_o;
  logic [1:0] ld_used_o;
  logic [0:0] st_used_o;

  int errors = 0, checks = 0;
  bit done = 0;
  int m_ld = 0, m_st = 0, m_blk = 0;

  always #2.5 clk = ~clk;

  cache_port_limiter uut (
    .clk_i(clk), .rst_ni, .tick_i, .ld_claim_i, .st_claim_i,
    .blk_set_i, .retry_i, .takeover_i,
    .ld_avail_o, .st_avail_o, .ld_used_o, .st_used_o, .blocked_o, .wake_o
  );

  task automatic chk(string tag, string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s %s: actual=%0d expected=%0d", req, tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag, bit tk, bit rt);
    int exp_wake;
    exp_wake = ((tk && m_ld == LD && m_blk == 0) || rt) ? 1 : 0;
    chk(tag, "R3", "ld_used", int'(ld_used_o), m_ld);
    chk(tag, "R3", "st_used", int'(st_used_o), m_st);
    chk(tag, "R1", "ld_avail", int'(ld_avail_o), (m_ld < LD) ? 1 : 0);
    chk(tag, "R2", "st_avail", int'(st_avail_o), (m_st < ST) ? 1 : 0);
    chk(tag, "R7", "blocked", int'(blocked_o), m_blk);
    chk(tag, "R5", "wake", int'(wake_o), exp_wake);
  endtask

  // legal claims only; over-claims are the R9 assertion's concern
  task automatic step(bit tk, int lc, int sc, bit st, bit rt, bit to, string tag);
    @(negedge clk);
    tick_i = tk; ld_claim_i = 2'(lc); st_claim_i = 1'(sc);
    blk_set_i = st; retry_i = rt; takeover_i = to;
    #1;
    compare(tag, tk, rt);
    @(posedge clk);
    m_ld = (tk ? 0 : m_ld) + lc;
    m_st = ((tk || to) ? 0 : m_st) + sc;
    if (rt || to) m_blk = 0;
    else if (st)  m_blk = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    compare("R10", 0, 0);
    rst_ni = 1'b1;
    // R3 accumulate to the limits
    step(0, 1, 0, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, "R3");   // full on both sides: R1 R2
    // R5 tick after full loads, not blocked
    step(1, 0, 0, 0, 0, 0, "R5");
    // R4 tick with claims charged to the new cycle
    step(0, 2, 0, 0, 0, 0, "R4");
    step(1, 1, 1, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, "R4");
    // R7 blocked, then R5 tick suppressed while blocked
    step(0, 0, 0, 1, 0, 0, "R7");
    step(1, 0, 0, 0, 0, 0, "R5");
    // R6 retry wakes and clears
    step(0, 0, 0, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    // R7 set and retry together resolve to clear
    step(0, 0, 0, 1, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    // R8 takeover: store count and blocked clear, loads kept
    step(0, 2, 1, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 1, 1, 0, 1, "R8");   // takeover with store claim, set loses
    step(0, 0, 0, 0, 0, 0, "R8");
    // random legal traffic
    for (int i = 0; i < 3000; i++) begin
      bit tk, to;
      int lc, sc;
      tk = ($urandom_range(0, 3) == 0);
      to = ($urandom_range(0, 29) == 0);
      lc = $urandom_range(0, LD - (tk ? 0 : m_ld));
      sc = $urandom_range(0, ST - ((tk || to) ? 0 : m_st));
      step(tk, lc, sc, ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 9) == 0), to, "RND");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule